// File: doc/BRIEF.md
# Codec Serial Port with In-Band Control Tagging

This block is a synchronous serial port that talks to an audio or telephony codec. The codec supplies the serial clock and the frame sync. The port moves 16-bit words between two 16-entry FIFOs and a pair of serial data lines. On the transmit side, each frame carries one primary word. If the next queued entry is marked as a control word, that control word follows the primary word directly in the same frame. On the receive side, each frame delivers one 16-bit word into the receive FIFO.

Software sets up the port through a small register bus. It has two registers: a 16-bit configuration register (address 0) and an enable register (address 1). Data enters through a valid/ready stream and leaves through another. A transmit word is accepted in any cycle where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low while the transmit FIFO holds 16 entries. A receive word is consumed in any cycle where `rx_valid` and `rx_ready` are both high, and `rx_valid` is low while the receive FIFO is empty or being flushed. A source may hold `tx_valid` high for any length of time, and `rx_data` stays steady until it is taken.

A tagging transfer mode lets the codec tell primary words from control words without any extra pin. In this mode the least significant bit of each primary word on the wire is replaced by a flag, and the flag is 1 exactly when a control word follows in the same frame.

Top module: `codec_sport`

## Requirements
- R1: The configuration register resets to 0x0000. Its layout is: bits [3:0] transmit watermark, [7:4] receive watermark, [9] receive flush, [10] bit order (1 = LSB first), [11] tagging mode. Bits [15:12] and [8] always read 0, whatever is written to them.
- R2: With tagging mode 0, every transmitted word goes out with all 16 bits exactly as queued, including bit 0.
- R3: With tagging mode 1, bit 0 of a transmitted primary word is 1 if a control word follows it in the frame, and 0 otherwise. Control words are never altered.
- R4: With bit order 0, words are shifted MSB first. With bit order 1, they are shifted LSB first. The setting applies to both transmit and receive.
- R5: While either enable is set, writes to the tagging mode, bit order and both watermark fields are ignored. The receive flush bit stays writable at all times.
- R6: While the flush bit is 1, the receive FIFO is empty, arriving words are discarded, and the overrun flag is cleared. The enable register is not changed. Once the flush bit is cleared, reception resumes.
- R7: The sync is sampled on a rising serial clock edge. The next 16 rising edges (32 if a control word is sent) carry the data bits. The port drives `sdo` after each falling edge, and `sdo` is 0 outside a frame. A frame starts only when the transmit FIFO is not empty.
- R8: `tx_req` is high while the transmit FIFO count is at or below the transmit watermark. `rx_hit` is high while the receive FIFO count is non-zero and at or above the receive watermark.
- R9: A received word that arrives while the receive FIFO holds 16 entries is dropped. It sets `rx_overrun`, which stays set until a flush.
- R10: The two stream interfaces follow the valid/ready rules above, and words come out of each FIFO in the order they went in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = configuration, 1 = enables |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit FIFO can accept |
| tx_data | input | 16 | Transmit word |
| tx_ctrl | input | 1 | 1 = control word, 0 = primary word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the word |
| rx_data | output | 16 | Oldest received word |
| tx_req | output | 1 | Transmit FIFO at or below watermark |
| rx_hit | output | 1 | Receive FIFO at or above watermark |
| rx_overrun | output | 1 | Sticky receive overflow flag |
| sck | input | 1 | Serial clock from the codec |
| fs | input | 1 | Frame sync from the codec |
| sdi | input | 1 | Serial receive data |
| sdo | output | 1 | Serial transmit data |

Enable register bits: bit 0 enables transmit and bit 1 enables receive.

## Verification
The hardest state to reach from the ports has the receive FIFO completely full, the overrun flag set, and a flush held while frames keep arriving. Reaching it means holding `rx_ready` low while serial frames pile up. The bench does this by first loading all 16 transmit entries, so that the frames draining the transmit side also overfill the receive side. The tagging case also needs care, because the flag depends on what is already queued when the sync arrives. So the bench pushes each primary word together with its control word before it raises the sync.

// File: rtl/csp_pkg.sv
package csp_pkg;
  localparam int WORD_W = 16;
  localparam int WM_W   = 4;

  typedef struct packed {
    logic [3:0]      rsvd_hi;
    logic            tag_mode;
    logic            lsb_first;
    logic            rx_flush;
    logic            rsvd_lo;
    logic [WM_W-1:0] rx_wm;
    logic [WM_W-1:0] tx_wm;
  } cfg_t;

  localparam logic [15:0] CFG_MASK  = 16'h0EFF;
  localparam logic [15:0] FLUSH_BIT = 16'h0200;
endpackage

// File: rtl/csp_fifo.sv
module csp_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic          rd_two,
  output logic [W-1:0]  head,
  output logic [W-1:0]  next,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] pop_n;

  assign pop_n = rd_en ? (rd_two ? CW'(2) : CW'(1)) : '0;
  assign full  = (count == CW'(DEPTH));
  assign head  = mem[rp];
  assign next  = mem[rp + AW'(1)];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (wr_en) wp <= wp + AW'(1);
      rp    <= rp + AW'(pop_n);
      count <= count + CW'(wr_en) - pop_n;
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (count >= pop_n));
endmodule

// File: rtl/csp_tx.sv
module csp_tx #(
  parameter int W  = 16,
  parameter int CW = 5,
  localparam int IW = $clog2(2 * W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tag_mode,
  input  logic          lsb_first,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          fs,
  input  logic [W:0]    head,
  input  logic [W:0]    next,
  input  logic [CW-1:0] count,
  output logic          pop,
  output logic          pop_two,
  output logic          sdo
);
  logic          active, len2, has_ctrl, start, last, bit_out;
  logic [IW-1:0] idx;
  logic [IW-2:0] pos;
  logic [W-1:0]  w0, w1, prim, cur;

  assign has_ctrl = (count >= CW'(2)) && next[W];
  assign start    = sck_rise && fs && en && !active && (count != '0);
  assign pop      = start;
  assign pop_two  = start && has_ctrl;

  always_comb begin
    prim = head[W-1:0];
    if (tag_mode && !head[W]) prim[0] = has_ctrl;
  end

  assign cur     = idx[IW-1] ? w1 : w0;
  assign pos     = idx[IW-2:0];
  assign bit_out = lsb_first ? cur[pos] : cur[(IW-1)'(W-1) - pos];
  assign last    = (idx == (len2 ? IW'(2*W-1) : IW'(W-1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; len2 <= 1'b0; idx <= '0;
      w0 <= '0; w1 <= '0; sdo <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      len2   <= has_ctrl;
      idx    <= '0;
      w0     <= prim;
      w1     <= next[W-1:0];
    end else if (sck_fall) begin
      if (active) begin
        sdo <= bit_out;
        idx <= idx + IW'(1);
        if (last) active <= 1'b0;
      end else begin
        sdo <= 1'b0;
      end
    end
  end

  p_sdo_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && !active) |=> !sdo);
endmodule

// File: rtl/csp_rx.sv
module csp_rx #(
  parameter int W = 16,
  localparam int NW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         lsb_first,
  input  logic         sck_rise,
  input  logic         fs,
  input  logic         sdi,
  output logic         push,
  output logic [W-1:0] data
);
  logic          active;
  logic [NW-1:0] cnt;
  logic [W-1:0]  shifted;

  assign shifted = lsb_first ? {sdi, data[W-1:1]} : {data[W-2:0], sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; cnt <= '0; data <= '0; push <= 1'b0;
    end else begin
      push <= 1'b0;
      if (sck_rise) begin
        if (active) begin
          data <= shifted;
          cnt  <= cnt + NW'(1);
          if (cnt == NW'(W-1)) begin
            active <= 1'b0;
            push   <= 1'b1;
          end
        end else if (fs && en) begin
          active <= 1'b1;
          cnt    <= '0;
        end
      end
    end
  end

  p_push_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);
endmodule

// File: rtl/codec_sport.sv
module codec_sport
  import csp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int W    = WORD_W,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wen,
  input  logic         reg_addr,
  input  logic [15:0]  reg_wdata,
  output logic [15:0]  reg_rdata,
  input  logic         tx_valid,
  output logic         tx_ready,
  input  logic [W-1:0] tx_data,
  input  logic         tx_ctrl,
  output logic         rx_valid,
  input  logic         rx_ready,
  output logic [W-1:0] rx_data,
  output logic         tx_req,
  output logic         rx_hit,
  output logic         rx_overrun,
  input  logic         sck,
  input  logic         fs,
  input  logic         sdi,
  output logic         sdo
);
  logic [15:0] cfg_q;
  cfg_t        cfg;
  logic        tx_en, rx_en, locked;
  logic [2:0]  sck_m;
  logic [1:0]  fs_m, sdi_m;
  logic        sck_rise, sck_fall;

  assign cfg    = cfg_t'(cfg_q);
  assign locked = tx_en || rx_en;

  // Codec clock domain is oversampled: two-flop synchronizers, then edge detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m <= '0; fs_m <= '0; sdi_m <= '0;
    end else begin
      sck_m <= {sck_m[1:0], sck};
      fs_m  <= {fs_m[0], fs};
      sdi_m <= {sdi_m[0], sdi};
    end
  end
  assign sck_rise = sck_m[1] && !sck_m[2];
  assign sck_fall = !sck_m[1] && sck_m[2];

  // Register bus
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; tx_en <= 1'b0; rx_en <= 1'b0;
    end else if (reg_wen) begin
      if (!reg_addr)
        cfg_q <= (locked ? ((cfg_q & ~FLUSH_BIT) | (reg_wdata & FLUSH_BIT))
                         : reg_wdata) & CFG_MASK;
      else begin
        tx_en <= reg_wdata[0];
        rx_en <= reg_wdata[1];
      end
    end
  end
  assign reg_rdata = reg_addr ? {14'd0, rx_en, tx_en} : cfg;

  // Transmit path
  logic [W:0]    tx_head, tx_next;
  logic [CW-1:0] tx_count;
  logic          tx_full, tx_pop, tx_pop_two;

  assign tx_ready = !tx_full;

  csp_fifo #(.W(W + 1), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n, .clr(1'b0),
    .wr_en(tx_valid && !tx_full), .wr_data({tx_ctrl, tx_data}),
    .rd_en(tx_pop), .rd_two(tx_pop_two),
    .head(tx_head), .next(tx_next), .count(tx_count), .full(tx_full));

  csp_tx #(.W(W), .CW(CW)) u_tx (
    .clk, .rst_n, .en(tx_en), .tag_mode(cfg.tag_mode), .lsb_first(cfg.lsb_first),
    .sck_rise, .sck_fall, .fs(fs_m[1]),
    .head(tx_head), .next(tx_next), .count(tx_count),
    .pop(tx_pop), .pop_two(tx_pop_two), .sdo);

  // Receive path
  logic [W-1:0]  rx_word, rx_next;
  logic [CW-1:0] rx_count;
  logic          rx_full, rx_push;

  csp_rx #(.W(W)) u_rx (
    .clk, .rst_n, .en(rx_en), .lsb_first(cfg.lsb_first),
    .sck_rise, .fs(fs_m[1]), .sdi(sdi_m[1]),
    .push(rx_push), .data(rx_word));

  assign rx_valid = (rx_count != '0) && !cfg.rx_flush;

  csp_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n, .clr(cfg.rx_flush),
    .wr_en(rx_push && !rx_full && !cfg.rx_flush), .wr_data(rx_word),
    .rd_en(rx_valid && rx_ready), .rd_two(1'b0),
    .head(rx_data), .next(rx_next), .count(rx_count), .full(rx_full));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          rx_overrun <= 1'b0;
    else if (cfg.rx_flush)               rx_overrun <= 1'b0;
    else if (rx_push && rx_full)         rx_overrun <= 1'b1;
  end

  assign tx_req = (tx_count <= CW'(cfg.tx_wm));
  assign rx_hit = (rx_count != '0) && (rx_count >= CW'(cfg.rx_wm));

  p_cfg_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(cfg_q[11:10]) && $stable(cfg_q[7:0])));
  p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.rx_flush |=> (rx_count == '0));
  p_overrun_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !cfg.rx_flush) |=> rx_overrun);
  p_rx_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_count >= CW'(2) && !cfg.rx_flush)
      |=> (rx_data == $past(rx_next)));
endmodule

// File: tb/sim_codec_sport.sv
module sim_codec_sport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0, reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        tx_valid = 1'b0, tx_ready, tx_ctrl = 1'b0;
  logic [15:0] tx_data = '0, rx_data;
  logic        rx_valid, rx_ready, tx_req, rx_hit, rx_overrun;
  logic        sck = 1'b0, fs = 1'b0, sdi = 1'b0, sdo;
  logic        drain_en = 1'b1;

  int n_chk = 0, n_err = 0;
  logic b_mode = 1'b0, b_lsbf = 1'b0, b_flush = 1'b0;
  logic [31:0] txq [$];
  logic [15:0] rxq [$];

  assign rx_ready = drain_en;
  always #5 clk = ~clk;

  codec_sport u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rev(input logic [15:0] v);
    for (int i = 0; i < 16; i++) rev[i] = v[15 - i];
  endfunction

  function automatic logic [15:0] wire_of(input logic [15:0] v);
    return b_lsbf ? rev(v) : v;
  endfunction

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wen = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic push_word(input logic [15:0] d, input logic c);
    @(negedge clk); tx_valid = 1'b1; tx_data = d; tx_ctrl = c;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 1'b0;
  endtask

  // driver: queue the words and the frame the codec must see
  task automatic send(input logic [15:0] p, input logic hc, input logic [15:0] c);
    logic [15:0] pw;
    pw = b_mode ? {p[15:1], hc} : p;
    push_word(p, 1'b0);
    if (hc) push_word(c, 1'b1);
    txq.push_back(hc ? {wire_of(pw), wire_of(c)} : {wire_of(pw), 16'h0000});
  endtask

  // codec model: sync, 32 bit periods, 2 idle periods
  task automatic frame(input logic [15:0] rxw);
    logic [31:0] cap, exp;
    if (!b_flush && rxq.size() < 16) rxq.push_back(b_lsbf ? rev(rxw) : rxw);
    sck = 1'b0; fs = 1'b1; sdi = 1'b0; half();
    sck = 1'b1; half();
    fs = 1'b0;
    for (int j = 0; j < 32; j++) begin
      sck = 1'b0; sdi = (j < 16) ? rxw[15 - j] : 1'b0; half();
      cap[31 - j] = sdo; sck = 1'b1; half();
    end
    for (int k = 0; k < 2; k++) begin
      sck = 1'b0; half(); sck = 1'b1; half();
    end
    sck = 1'b0; half();
    exp = (txq.size() != 0) ? txq.pop_front() : 32'h0;
    check("R7/R2/R3 tx frame", cap, exp);
  endtask

  // monitor: compare each accepted receive word with the scoreboard
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (rxq.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R10 rx word act=%h exp=none", rx_data);
      end else begin
        check("R4/R10 rx word", {16'h0, rx_data}, {16'h0, rxq.pop_front()});
      end
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=done");
    report();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    rd(1'b0, d); check("R1 cfg reset", d, 16'h0000);
    check("R8 tx_req at reset", tx_req, 1'b1);
    check("R10 rx_valid at reset", rx_valid, 1'b0);
    check("R10 tx_ready at reset", tx_ready, 1'b1);
    check("R7 sdo idle", sdo, 1'b0);
    wr(1'b0, 16'hFFFF); rd(1'b0, d); check("R1 reserved bits", d, 16'h0EFF);
    wr(1'b0, 16'h0000);

    // R2 mode 0, MSB first
    wr(1'b1, 16'h0003);
    send(16'hA5A5, 1'b0, 16'h0); frame(16'h1234);
    send(16'h00FF, 1'b1, 16'h8001); frame(16'hC3C3);

    // R5 locked fields
    wr(1'b0, 16'h0C33); rd(1'b0, d); check("R5 locked write ignored", d, 16'h0000);
    wr(1'b0, 16'h0200); rd(1'b0, d); check("R5 flush still writable", d, 16'h0200);
    wr(1'b0, 16'h0000);

    // R3 tagging mode
    wr(1'b1, 16'h0000); wr(1'b0, 16'h0800); rd(1'b0, d);
    check("R3 mode set", d, 16'h0800);
    wr(1'b1, 16'h0003); b_mode = 1'b1;
    send(16'h1235, 1'b0, 16'h0); frame(16'h0F0F);
    send(16'h1234, 1'b1, 16'hBEEE); frame(16'h8001);
    send(16'hFFFF, 1'b1, 16'h0001); frame(16'h7FFE);

    // R4 LSB first
    wr(1'b1, 16'h0000); wr(1'b0, 16'h0400); wr(1'b1, 16'h0003);
    b_mode = 1'b0; b_lsbf = 1'b1;
    send(16'h1203, 1'b1, 16'h8000); frame(16'h00F1);

    // R8 watermarks
    wr(1'b1, 16'h0000); wr(1'b0, 16'h0032); wr(1'b1, 16'h0003);
    b_lsbf = 1'b0; repeat (10) @(negedge clk); drain_en = 1'b0;
    for (int i = 0; i < 3; i++) send(16'h1111 * 16'(i + 1), 1'b0, 16'h0);
    check("R8 tx_req above watermark", tx_req, 1'b0);
    frame(16'h0101);
    check("R8 tx_req at watermark", tx_req, 1'b1);
    frame(16'h0202);
    check("R8 rx_hit below watermark", rx_hit, 1'b0);
    frame(16'h0303);
    check("R8 rx_hit at watermark", rx_hit, 1'b1);

    // R10 transmit full, R9 receive overflow
    for (int i = 0; i < 16; i++) send(16'h2000 + 16'(i), 1'b0, 16'h0);
    check("R10 tx_ready when full", tx_ready, 1'b0);
    for (int i = 0; i < 13; i++) frame(16'h4000 + 16'(i));
    check("R9 no overrun at exactly full", rx_overrun, 1'b0);
    for (int i = 0; i < 3; i++) frame(16'h6000 + 16'(i));
    check("R9 overrun after drop", rx_overrun, 1'b1);
    check("R10 tx_ready after drain", tx_ready, 1'b1);

    // R6 flush held while frames arrive
    wr(1'b0, 16'h0232); b_flush = 1'b1; rxq.delete();
    repeat (2) @(negedge clk);
    check("R6 rx empty on flush", rx_valid, 1'b0);
    check("R6 overrun cleared", rx_overrun, 1'b0);
    frame(16'h7777);
    check("R6 rx stays empty", rx_valid, 1'b0);
    rd(1'b1, d); check("R6 enables kept", d, 16'h0003);
    wr(1'b0, 16'h0032); b_flush = 1'b0; drain_en = 1'b1;
    frame(16'h5A5A);
    repeat (20) @(negedge clk);
    check("R6 reception resumed", rxq.size(), 0);
    check("R10 tx scoreboard drained", txq.size(), 0);
    report();
  end
endmodule